// File: doc/BRIEF.md
# Indexed interrupt-controller register window

This block is the host-facing register file of an I/O interrupt controller. The host cannot reach the internal registers directly. It writes an 8-bit selector into a select register, then reads or writes a 32-bit data window, and the selector decides which internal register the window reaches. Behind the window sit an identification register, a fixed version word, a read-only arbitration word that mirrors the identification value, and a table of redirection entries. Each entry is 64 bits wide and is reached as two 32-bit halves.

The host owns the configuration fields of each entry. The delivery-status and remote-IRR flags are owned by the per-pin trigger logic, which sets and clears them through dedicated strobes. Host writes cannot change those two flags. A host write that moves an entry from level to edge triggering clears its remote-IRR flag. The mask, trigger mode, polarity, remote-IRR and delivery-status bits of every entry are exported as per-pin vectors for the trigger logic.

Accesses use byte offset 0x00 for the select register and 0x10 for the data window. A read returns its data one cycle after the read strobe, together with a valid flag.

Top module: `irq_regwin`

## Requirements
- R1: A read at offset 0x00 returns the last selector written there in bits 7:0 and zeros above. Every read strobe produces rvalid_o with its data exactly one cycle later. Accesses at offsets other than 0x00 and 0x10 read 0 and write nothing.
- R2: Selector 0x01 reads 0x00170011 at all times, and window writes to it are ignored.
- R3: Selector 0x00 holds a 4-bit identifier taken from bits 27:24 of a window write. A read returns it in bits 27:24 and zeros elsewhere, so writing 0x1f3e5d7c reads back 0x0f000000.
- R4: Selector 0x02 is read-only. It returns the same word as selector 0x00 and follows writes made there.
- R5: Selectors 0x03 to 0x0F read 0, and writes to them change no register.
- R6: Entry n is reached at selector 0x10+2n (bits 31:0) and 0x11+2n (bits 63:32). The layout is: vector 7:0, delivery mode 10:8, destination mode 11, delivery status 12, polarity 13, remote IRR 14, trigger 15 (1 = level), mask 16, reserved 55:17 (always read 0), destination 63:56. Mask, trigger and polarity of each entry appear on the export vectors.
- R7: A selector that decodes to an entry index of 24 or more (0x40 to 0xFF) reads 0xFFFFFFFF.
- R8: Delivery status and remote IRR change only through the set and clear strobes, one cycle after the strobe (clear wins). A host write keeps their current values.
- R9: A low-half write that changes an entry from level to edge clears its remote IRR. Writes that only mask and then unmask the entry leave remote IRR set.
- R10: After reset the selector and identifier are 0, every entry has mask = 1, and every other entry bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| addr_i | input | 8 | Byte offset (0x00 select, 0x10 window) |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_en_i |
| dstat_set_i | input | 24 | Per-entry delivery-status set strobes |
| dstat_clr_i | input | 24 | Per-entry delivery-status clear strobes |
| rirr_set_i | input | 24 | Per-entry remote-IRR set strobes |
| rirr_clr_i | input | 24 | Per-entry remote-IRR clear strobes |
| pin_mask_o | output | 24 | Per-entry mask bit |
| pin_level_o | output | 24 | Per-entry trigger mode (1 = level) |
| pin_pol_o | output | 24 | Per-entry polarity |
| pin_rirr_o | output | 24 | Per-entry remote IRR |
| pin_dstat_o | output | 24 | Per-entry delivery status |

## Verification
Read data is due exactly one cycle after the read strobe. The bench's driver queues each expected word when it raises the strobe, and the monitor pops and compares the word at the falling edge after the next rising edge, when rvalid_o is high. Register writes and hardware strobes take effect at the edge that samples them. Every read or export check is therefore placed at least one full cycle after the stimulus. Export vectors are sampled at a falling edge once the write cycle has finished.

// File: rtl/irqw_pkg.sv
package irqw_pkg;

    localparam int          DATA_W    = 32;
    localparam int          SEL_W     = 8;
    localparam logic [7:0]  OFF_SEL   = 8'h00;
    localparam logic [7:0]  OFF_WIN   = 8'h10;
    localparam logic [7:0]  SEL_IDENT = 8'h00;
    localparam logic [7:0]  SEL_VERS  = 8'h01;
    localparam logic [7:0]  SEL_ARBW  = 8'h02;
    localparam logic [7:0]  SEL_TABLE = 8'h10;
    localparam logic [31:0] VERSION_WORD = 32'h0017_0011;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_IDENT,
        TGT_VERS,
        TGT_ARBW,
        TGT_ENTRY,
        TGT_RANGE
    } tgt_e;

    // Host-owned part of a redirection entry
    typedef struct packed {
        logic [7:0] dest;
        logic       mask;
        logic       level;
        logic       pol;
        logic       dmode;
        logic [2:0] deliv;
        logic [7:0] vec;
    } ent_cfg_t;

    localparam ent_cfg_t CFG_RESET = '{dest: 8'h00, mask: 1'b1, level: 1'b0,
                                       pol: 1'b0, dmode: 1'b0, deliv: 3'd0,
                                       vec: 8'h00};

    function automatic logic [31:0] pack_low(ent_cfg_t c, logic ds, logic rirr);
        return {15'd0, c.mask, c.level, rirr, c.pol, ds, c.dmode, c.deliv, c.vec};
    endfunction

    function automatic logic [31:0] pack_high(ent_cfg_t c);
        return {c.dest, 24'd0};
    endfunction

    function automatic ent_cfg_t apply_low(ent_cfg_t c, logic [31:0] w);
        ent_cfg_t r;
        r       = c;
        r.vec   = w[7:0];
        r.deliv = w[10:8];
        r.dmode = w[11];
        r.pol   = w[13];
        r.level = w[15];
        r.mask  = w[16];
        return r;
    endfunction

    function automatic ent_cfg_t apply_high(ent_cfg_t c, logic [31:0] w);
        ent_cfg_t r;
        r      = c;
        r.dest = w[31:24];
        return r;
    endfunction

endpackage

// File: rtl/irqw_sel_decode.sv
module irqw_sel_decode
    import irqw_pkg::*;
#(
    parameter int N_ENTRIES = 24,
    localparam int IDX_W = SEL_W - 1
) (
    input  logic [SEL_W-1:0] sel_i,
    output tgt_e             tgt_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             hi_o
);

    logic [SEL_W-1:0] rel;

    always_comb begin
        rel   = sel_i - SEL_TABLE;
        idx_o = rel[SEL_W-1:1];
        hi_o  = rel[0];
        if (sel_i >= SEL_TABLE) begin
            if (int'(idx_o) < N_ENTRIES) tgt_o = TGT_ENTRY;
            else                         tgt_o = TGT_RANGE;
        end else begin
            case (sel_i)
                SEL_IDENT: tgt_o = TGT_IDENT;
                SEL_VERS:  tgt_o = TGT_VERS;
                SEL_ARBW:  tgt_o = TGT_ARBW;
                default:   tgt_o = TGT_NONE;
            endcase
        end
    end

    // R7: an out-of-range table index never decodes as a live entry
    always_comb begin
        if (tgt_o == TGT_ENTRY)
            a_r7_idx_in_range: assert (int'(idx_o) < N_ENTRIES);
    end

endmodule

// File: rtl/irqw_entry.sv
module irqw_entry
    import irqw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_low_i,
    input  logic        wr_high_i,
    input  logic [31:0] wdata_i,
    input  logic        ds_set_i,
    input  logic        ds_clr_i,
    input  logic        rirr_set_i,
    input  logic        rirr_clr_i,
    output ent_cfg_t    cfg_o,
    output logic        ds_o,
    output logic        rirr_o
);

    ent_cfg_t cfg_q;
    logic     ds_q;
    logic     rirr_q;
    logic     to_edge;

    // Level to edge transition requested by a host write
    assign to_edge = wr_low_i && cfg_q.level && !wdata_i[15];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= CFG_RESET;
            ds_q   <= 1'b0;
            rirr_q <= 1'b0;
        end else begin
            if (wr_low_i)       cfg_q <= apply_low(cfg_q, wdata_i);
            else if (wr_high_i) cfg_q <= apply_high(cfg_q, wdata_i);
            ds_q <= (ds_q | ds_set_i) & ~ds_clr_i;
            if (to_edge) rirr_q <= 1'b0;
            else         rirr_q <= (rirr_q | rirr_set_i) & ~rirr_clr_i;
        end
    end

    assign cfg_o  = cfg_q;
    assign ds_o   = ds_q;
    assign rirr_o = rirr_q;

    // R9: leaving level mode through a host write drops remote IRR
    a_r9_edge_clears_rirr: assert property (@(posedge clk) disable iff (rst)
        to_edge |=> !rirr_o);

    // R8: without hardware strobes a host write leaves both status flags alone
    a_r8_status_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_low_i && !to_edge && !rirr_set_i && !rirr_clr_i && !ds_set_i && !ds_clr_i)
        |=> (rirr_o == $past(rirr_o)) && (ds_o == $past(ds_o)));

endmodule

// File: rtl/irq_regwin.sv
module irq_regwin
    import irqw_pkg::*;
#(
    parameter int N_ENTRIES = 24,
    localparam int IDX_W = SEL_W - 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en_i,
    input  logic                 rd_en_i,
    input  logic [7:0]           addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rdata_o,
    output logic                 rvalid_o,
    input  logic [N_ENTRIES-1:0] dstat_set_i,
    input  logic [N_ENTRIES-1:0] dstat_clr_i,
    input  logic [N_ENTRIES-1:0] rirr_set_i,
    input  logic [N_ENTRIES-1:0] rirr_clr_i,
    output logic [N_ENTRIES-1:0] pin_mask_o,
    output logic [N_ENTRIES-1:0] pin_level_o,
    output logic [N_ENTRIES-1:0] pin_pol_o,
    output logic [N_ENTRIES-1:0] pin_rirr_o,
    output logic [N_ENTRIES-1:0] pin_dstat_o
);

    logic [SEL_W-1:0]  sel_q;
    logic [3:0]        ident_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;

    tgt_e              tgt;
    logic [IDX_W-1:0]  idx;
    logic              hi;

    logic              wr_sel, wr_win, rd_win;
    logic [N_ENTRIES-1:0] wr_lo_v, wr_hi_v;

    ent_cfg_t          cfg_a  [N_ENTRIES];
    logic [N_ENTRIES-1:0] ds_a, rirr_a;

    logic [DATA_W-1:0] ident_word, ent_word, win_word, rd_next;

    assign wr_sel = wr_en_i && (addr_i == OFF_SEL);
    assign wr_win = wr_en_i && (addr_i == OFF_WIN);
    assign rd_win = rd_en_i && (addr_i == OFF_WIN);

    irqw_sel_decode #(.N_ENTRIES(N_ENTRIES)) u_dec (
        .sel_i (sel_q),
        .tgt_o (tgt),
        .idx_o (idx),
        .hi_o  (hi)
    );

    generate
        for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
            assign wr_lo_v[g] = wr_win && (tgt == TGT_ENTRY) && (idx == IDX_W'(g)) && !hi;
            assign wr_hi_v[g] = wr_win && (tgt == TGT_ENTRY) && (idx == IDX_W'(g)) && hi;

            irqw_entry u_ent (
                .clk        (clk),
                .rst        (rst),
                .wr_low_i   (wr_lo_v[g]),
                .wr_high_i  (wr_hi_v[g]),
                .wdata_i    (wdata_i),
                .ds_set_i   (dstat_set_i[g]),
                .ds_clr_i   (dstat_clr_i[g]),
                .rirr_set_i (rirr_set_i[g]),
                .rirr_clr_i (rirr_clr_i[g]),
                .cfg_o      (cfg_a[g]),
                .ds_o       (ds_a[g]),
                .rirr_o     (rirr_a[g])
            );

            assign pin_mask_o[g]  = cfg_a[g].mask;
            assign pin_level_o[g] = cfg_a[g].level;
            assign pin_pol_o[g]   = cfg_a[g].pol;
        end
    endgenerate

    assign pin_rirr_o  = rirr_a;
    assign pin_dstat_o = ds_a;

    // Select and identifier registers
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            ident_q <= '0;
        end else begin
            if (wr_sel) sel_q <= wdata_i[SEL_W-1:0];
            if (wr_win && tgt == TGT_IDENT) ident_q <= wdata_i[27:24];
        end
    end

    // Read path
    always_comb begin
        ident_word = {4'd0, ident_q, 24'd0};
        ent_word   = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (idx == IDX_W'(i))
                ent_word = hi ? pack_high(cfg_a[i]) : pack_low(cfg_a[i], ds_a[i], rirr_a[i]);
        end
        case (tgt)
            TGT_IDENT, TGT_ARBW: win_word = ident_word;
            TGT_VERS:            win_word = VERSION_WORD;
            TGT_ENTRY:           win_word = ent_word;
            TGT_RANGE:           win_word = '1;
            default:             win_word = '0;
        endcase
        if (addr_i == OFF_SEL)      rd_next = {{(DATA_W-SEL_W){1'b0}}, sel_q};
        else if (addr_i == OFF_WIN) rd_next = win_word;
        else                        rd_next = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd_en_i;
            if (rd_en_i) rdata_q <= rd_next;
        end
    end

    assign rdata_o  = rdata_q;
    assign rvalid_o = rvalid_q;

    // R1: read data arrives exactly one cycle after the strobe
    a_r1_read_latency: assert property (@(posedge clk) disable iff (rst)
        rd_en_i |=> rvalid_o);

    // R2: the version selector always reads the fixed word
    a_r2_version_fixed: assert property (@(posedge clk) disable iff (rst)
        (rd_win && sel_q == SEL_VERS) |=> (rdata_o == VERSION_WORD));

    // R3: identifier reads carry data only in bits 27:24
    a_r3_ident_field: assert property (@(posedge clk) disable iff (rst)
        (rd_win && sel_q == SEL_IDENT) |=> (rdata_o[31:28] == 4'd0 && rdata_o[23:0] == 24'd0));

    // R7: selectors past the table read all ones
    a_r7_range_ones: assert property (@(posedge clk) disable iff (rst)
        (rd_win && int'(sel_q) >= int'(SEL_TABLE) + 2 * N_ENTRIES) |=> (rdata_o == '1));

    // R4: the arbitration word never differs from the identifier word
    a_r4_arb_mirror: assert property (@(posedge clk) disable iff (rst)
        (rd_win && sel_q == SEL_ARBW) |=> (rdata_o[27:24] == $past(ident_q)));

endmodule

// File: tb/irq_regwin_tb_top.sv
module irq_regwin_tb_top;

    localparam int N = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          rvalid;
    logic [N-1:0]  ds_set = '0, ds_clr = '0, ri_set = '0, ri_clr = '0;
    logic [N-1:0]  p_mask, p_level, p_pol, p_rirr, p_dstat;

    int            n_tests = 0;
    int            n_fail  = 0;
    bit            done    = 1'b0;

    logic [31:0]   exp_q [$];
    string         tag_q [$];

    always #10 clk = ~clk;  // 50 MHz

    irq_regwin dut_i (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
        .dstat_set_i(ds_set), .dstat_clr_i(ds_clr),
        .rirr_set_i(ri_set), .rirr_clr_i(ri_clr),
        .pin_mask_o(p_mask), .pin_level_o(p_level), .pin_pol_o(p_pol),
        .pin_rirr_o(p_rirr), .pin_dstat_o(p_dstat)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compare read data against the scoreboard
    always @(negedge clk) begin
        if (!rst && rvalid) begin
            if (exp_q.size() == 0) begin
                check("R1 unexpected rvalid", 32'd1, 32'd0);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, rdata, e);
            end
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] e, string t);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr_reg(logic [7:0] s, logic [31:0] d);
        wr(8'h00, {24'd0, s});
        wr(8'h10, d);
    endtask

    task automatic rd_reg(logic [7:0] s, logic [31:0] e, string t);
        wr(8'h00, {24'd0, s});
        rd(8'h10, e, t);
    endtask

    task automatic pulse(ref logic [N-1:0] v, input int i);
        @(negedge clk);
        v[i] = 1'b1;
        @(negedge clk);
        v[i] = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        check("R10 masks after reset", 32'(p_mask), 32'(24'hFFFFFF));
        check("R10 level after reset", 32'(p_level | p_pol | p_rirr | p_dstat), 32'd0);
        rd(8'h00, 32'h0, "R10 selector after reset");
        rd_reg(8'h1A, 32'h0001_0000, "R10 entry 5 low after reset");
        rd_reg(8'h1B, 32'h0, "R10 entry 5 high after reset");

        // R1 select readback and unmapped offsets
        wr(8'h00, 32'hFFFF_FFA5);
        rd(8'h00, 32'h0000_00A5, "R1 selector readback");
        wr(8'h04, 32'h0000_0033);
        rd(8'h00, 32'h0000_00A5, "R1 write at unmapped offset ignored");
        rd(8'h08, 32'h0, "R1 unmapped offset reads 0");

        // R2 version
        wr_reg(8'h01, 32'hFFE8_FFEE);
        rd(8'h10, 32'h0017_0011, "R2 version after write");

        // R3 identifier
        wr_reg(8'h00, 32'h1F3E_5D7C);
        rd(8'h10, 32'h0F00_0000, "R3 identifier field");

        // R4 arbitration mirror
        rd_reg(8'h02, 32'h0F00_0000, "R4 arbitration mirrors identifier");
        wr(8'h10, 32'hE0C1_A283);
        rd(8'h10, 32'h0F00_0000, "R4 arbitration write ignored");
        wr_reg(8'h00, 32'h0300_0000);
        rd_reg(8'h02, 32'h0300_0000, "R4 arbitration follows new identifier");

        // R5 unused selectors
        wr_reg(8'h05, 32'hFFFF_FFFF);
        rd(8'h10, 32'h0, "R5 unused selector reads 0");
        rd_reg(8'h00, 32'h0300_0000, "R5 identifier unchanged");
        rd_reg(8'h0F, 32'h0, "R5 selector 0x0F reads 0");

        // R6 layout and selectors
        wr_reg(8'h3E, 32'hFFFF_FFFF);
        rd(8'h10, 32'h0001_AFFF, "R6 entry 23 low all-ones write");
        wr_reg(8'h3F, 32'hFFFF_FFFF);
        rd(8'h10, 32'hFF00_0000, "R6 entry 23 high reserved zero");
        check("R6 entry 23 exports", 32'({p_mask[23], p_level[23], p_pol[23]}), 32'h7);
        wr_reg(8'h10, 32'h0000_965F);
        rd(8'h10, 32'h0000_865F, "R6 entry 0 low");
        wr_reg(8'h11, 32'h3A00_0000);
        rd(8'h10, 32'h3A00_0000, "R6 entry 0 high");
        check("R6 entry 0 exports", 32'({p_mask[0], p_level[0], p_pol[0]}), 32'h2);

        // R7 out-of-range index
        rd_reg(8'h40, 32'hFFFF_FFFF, "R7 selector 0x40");
        rd_reg(8'hFF, 32'hFFFF_FFFF, "R7 selector 0xFF");
        rd_reg(8'h3F, 32'hFF00_0000, "R7 last valid selector");

        // R8 hardware-owned status
        pulse(ds_set, 0);
        pulse(ri_set, 0);
        rd_reg(8'h10, 32'h0000_D65F, "R8 status set by hardware");
        wr(8'h10, 32'h0000_805F);
        rd(8'h10, 32'h0000_D05F, "R8 host write keeps status");
        pulse(ds_clr, 0);
        rd(8'h10, 32'h0000_C05F, "R8 hardware clears delivery status");
        check("R8 exported remote IRR", 32'(p_rirr[0]), 32'd1);

        // R9 mask cycle keeps remote IRR, level to edge clears it
        wr(8'h10, 32'h0001_805F);
        rd(8'h10, 32'h0001_C05F, "R9 masked keeps remote IRR");
        wr(8'h10, 32'h0000_805F);
        rd(8'h10, 32'h0000_C05F, "R9 unmasked keeps remote IRR");
        wr(8'h10, 32'h0000_005F);
        rd(8'h10, 32'h0000_005F, "R9 level to edge clears remote IRR");
        check("R9 exported remote IRR cleared", 32'(p_rirr[0]), 32'd0);

        repeat (3) @(negedge clk);
        check("R1 all reads returned", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule